// File: doc/BRIEF.md
# Integer ALU Slice with Operation Decoder

This block takes one integer operation per handshake and returns a registered result. Each operation arrives with two 32-bit operands, a 2-bit operation class from the main control and the 6-bit function field of the instruction. A small decoder turns the class and the function field into one of five ALU functions: add, subtract, AND, OR and signed set-less-than. The ALU core then produces a 32-bit result. On subtraction it also produces a 2-bit compare code that branch logic uses.

The operation class works as follows. Class 00 requests an add, as used for address generation. Class 01 requests a subtract, as used for branch compares. In both of these classes the function field is not looked at. Class 10 marks a register-register instruction, and only then is the function field decoded.

Both edges of the block are valid/ready streams. An operation is accepted on a rising clock edge where `in_valid` and `in_ready` are both high. Its result is shown on the next cycle with `out_valid` high. The result is held unchanged until a cycle in which `out_ready` is high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle, so back-pressure passes through one register and is not buffered further.

Top module: `alu_slice`

## Requirements
- R1: While `rst_n` is low and after it is released, `out_valid` is 0. `out_result`, `out_cmp` and `out_cmp_valid` are 0 and `in_ready` is 1.
- R2: Class 00 gives `out_result` = (`in_a` + `in_b`) mod 2^32.
- R3: Class 01 gives `out_result` = (`in_a` − `in_b`) mod 2^32.
- R4: Class 10 decodes the function field. 0x20 gives add, 0x22 gives subtract, 0x24 gives bitwise AND and 0x25 gives bitwise OR.
- R5: Class 10 with function 0x2A gives 1 when `in_a` < `in_b` as signed 32-bit numbers, and 0 otherwise. Bits 31..1 are zero.
- R6: Class 10 with any function value not listed in R4 or R5 gives an add. Class 11 also gives an add, whatever the function field holds.
- R7: When the decoded function is subtract, `out_cmp_valid` is 1. `out_cmp[0]` is 1 exactly when `in_a` equals `in_b`, and `out_cmp[1]` is 1 exactly when `in_a` > `in_b` as signed numbers. The two bits are never both 1.
- R8: For any function other than subtract, `out_cmp_valid` is 0 and `out_cmp` is 00.
- R9: `in_ready` = !`out_valid` || `out_ready`. An accepted operation appears with `out_valid` high in the next cycle. If no operation is accepted and `out_ready` is high, `out_valid` falls.
- R10: While `out_valid` is 1 and `out_ready` is 0, the outputs stay unchanged into the next cycle.
- R11: For classes 00 and 01 the function field has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation present |
| in_ready | output | 1 | Block can take an operation this cycle |
| in_class | input | 2 | Operation class: 00 add, 01 subtract, 10 function-field decode, 11 add |
| in_func | input | 6 | Function field of the instruction |
| in_a | input | 32 | First operand |
| in_b | input | 32 | Second operand |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 32 | ALU result |
| out_cmp | output | 2 | Bit 0 equal, bit 1 signed greater-than |
| out_cmp_valid | output | 1 | Compare code is meaningful (subtract) |

## Verification
The only state in the block is the output register and its valid bit. A wrong valid bit shows up one cycle after the bad edge, either as a result that is lost or duplicated or as a wrong `in_ready` level. A result register that is captured at the wrong time changes under a stall within that same cycle. Decode or arithmetic faults cannot be seen until the result register has captured them. The reference model therefore compares every port on every cycle and uses operand values around the sign boundary, where the overflow correction in the signed comparison decides the answer.

// File: rtl/alu_slice_pkg.sv
package alu_slice_pkg;

  typedef enum logic [2:0] {
    FN_ADD = 3'd0,
    FN_SUB = 3'd1,
    FN_AND = 3'd2,
    FN_OR  = 3'd3,
    FN_SLT = 3'd4
  } alu_fn_e;

  localparam logic [1:0] CLS_MEM = 2'b00;
  localparam logic [1:0] CLS_BR  = 2'b01;
  localparam logic [1:0] CLS_REG = 2'b10;

  localparam logic [5:0] FUNCT_ADD = 6'h20;
  localparam logic [5:0] FUNCT_SUB = 6'h22;
  localparam logic [5:0] FUNCT_AND = 6'h24;
  localparam logic [5:0] FUNCT_OR  = 6'h25;
  localparam logic [5:0] FUNCT_SLT = 6'h2A;

  localparam int CMP_EQ_BIT = 0;
  localparam int CMP_GT_BIT = 1;

endpackage

// File: rtl/alu_op_decode.sv
module alu_op_decode
  import alu_slice_pkg::*;
#(
  parameter int CLS_W  = 2,
  parameter int FUNC_W = 6
) (
  input  logic [CLS_W-1:0]  op_class,
  input  logic [FUNC_W-1:0] func,
  output alu_fn_e           fn
);

  alu_fn_e reg_fn;

  always_comb begin
    case (func)
      FUNCT_ADD: reg_fn = FN_ADD;
      FUNCT_SUB: reg_fn = FN_SUB;
      FUNCT_AND: reg_fn = FN_AND;
      FUNCT_OR:  reg_fn = FN_OR;
      FUNCT_SLT: reg_fn = FN_SLT;
      default:   reg_fn = FN_ADD;
    endcase
  end

  always_comb begin
    case (op_class)
      CLS_MEM: fn = FN_ADD;
      CLS_BR:  fn = FN_SUB;
      CLS_REG: fn = reg_fn;
      default: fn = FN_ADD;
    endcase
  end

  // R3: the branch class always yields a subtract
  always_comb begin
    if (op_class == CLS_BR) begin
      p_branch_sub_r3: assert (fn == FN_SUB);
    end
  end

endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_slice_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_fn_e      fn,
  output logic [W-1:0] result,
  output logic [1:0]   cmp,
  output logic         cmp_valid
);

  logic [W-1:0] sum;
  logic [W-1:0] diff;
  logic         ovf;
  logic         lt;
  logic         eq;
  logic         gt;

  assign sum  = a + b;
  assign diff = a - b;
  // signed overflow of a - b: operands differ in sign and the result sign differs from a
  assign ovf  = (a[W-1] ^ b[W-1]) & (diff[W-1] ^ a[W-1]);
  assign lt   = diff[W-1] ^ ovf;
  assign eq   = (diff == '0);
  assign gt   = ~lt & ~eq;

  always_comb begin
    case (fn)
      FN_ADD:  result = sum;
      FN_SUB:  result = diff;
      FN_AND:  result = a & b;
      FN_OR:   result = a | b;
      FN_SLT:  result = {{(W-1){1'b0}}, lt};
      default: result = sum;
    endcase
  end

  always_comb begin
    cmp_valid = (fn == FN_SUB);
    cmp       = 2'b00;
    if (cmp_valid) begin
      cmp[CMP_EQ_BIT] = eq;
      cmp[CMP_GT_BIT] = gt;
    end
  end

  // R5: set-less-than leaves upper bits clear
  always_comb begin
    if (fn == FN_SLT) begin
      p_slt_upper_zero_r5: assert (result[W-1:1] == '0);
    end
  end

endmodule

// File: rtl/alu_out_stage.sv
module alu_out_stage #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] d_result,
  input  logic [1:0]   d_cmp,
  input  logic         d_cmp_valid,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] q_result,
  output logic [1:0]   q_cmp,
  output logic         q_cmp_valid
);

  logic take;

  assign in_ready = ~out_valid | out_ready;
  assign take     = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_result    <= '0;
      q_cmp       <= 2'b00;
      q_cmp_valid <= 1'b0;
    end else if (take) begin
      q_result    <= d_result;
      q_cmp       <= d_cmp;
      q_cmp_valid <= d_cmp_valid;
    end
  end

  p_accept_shows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  p_stall_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(q_result) && $stable(q_cmp)
                                   && $stable(q_cmp_valid)));

  p_cmp_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (q_cmp != 2'b11));

  p_cmp_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !q_cmp_valid) |-> (q_cmp == 2'b00));

endmodule

// File: rtl/alu_slice.sv
module alu_slice
  import alu_slice_pkg::*;
#(
  parameter int W      = 32,
  parameter int CLS_W  = 2,
  parameter int FUNC_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CLS_W-1:0]  in_class,
  input  logic [FUNC_W-1:0] in_func,
  input  logic [W-1:0]      in_a,
  input  logic [W-1:0]      in_b,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [W-1:0]      out_result,
  output logic [1:0]        out_cmp,
  output logic              out_cmp_valid
);

  alu_fn_e      fn;
  logic [W-1:0] c_result;
  logic [1:0]   c_cmp;
  logic         c_cmp_valid;

  alu_op_decode #(.CLS_W(CLS_W), .FUNC_W(FUNC_W)) u_decode (
    .op_class (in_class),
    .func     (in_func),
    .fn       (fn)
  );

  alu_core #(.W(W)) u_core (
    .a         (in_a),
    .b         (in_b),
    .fn        (fn),
    .result    (c_result),
    .cmp       (c_cmp),
    .cmp_valid (c_cmp_valid)
  );

  alu_out_stage #(.W(W)) u_stage (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .d_result    (c_result),
    .d_cmp       (c_cmp),
    .d_cmp_valid (c_cmp_valid),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .q_result    (out_result),
    .q_cmp       (out_cmp),
    .q_cmp_valid (out_cmp_valid)
  );

endmodule

// File: tb/alu_slice_tb.sv
`timescale 1ns/1ps
module alu_slice_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_class = 2'b00;
  logic [5:0]  in_func = 6'h00;
  logic [31:0] in_a = 32'h0;
  logic [31:0] in_b = 32'h0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_result;
  logic [1:0]  out_cmp;
  logic        out_cmp_valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit stall_mode = 1'b0;

  // reference model state
  bit          ev = 1'b0;
  logic [31:0] er = '0;
  logic [1:0]  ec = '0;
  bit          ecv = 1'b0;
  string       ereq = "R1";

  always #4 clk = ~clk;

  alu_slice u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_class(in_class), .in_func(in_func), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .out_cmp(out_cmp), .out_cmp_valid(out_cmp_valid)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic ref_calc(input logic [1:0] cls, input logic [5:0] fc,
                          input logic [31:0] a, input logic [31:0] b,
                          output logic [31:0] r, output logic [1:0] c,
                          output bit cv, output string req);
    int kind; // 0 add 1 sub 2 and 3 or 4 slt
    if (cls == 2'b00) begin kind = 0; req = "R2/R11"; end
    else if (cls == 2'b01) begin kind = 1; req = "R3/R11"; end
    else if (cls == 2'b11) begin kind = 0; req = "R6"; end
    else begin
      if (fc == 6'h20) begin kind = 0; req = "R4"; end
      else if (fc == 6'h22) begin kind = 1; req = "R4"; end
      else if (fc == 6'h24) begin kind = 2; req = "R4"; end
      else if (fc == 6'h25) begin kind = 3; req = "R4"; end
      else if (fc == 6'h2A) begin kind = 4; req = "R5"; end
      else begin kind = 0; req = "R6"; end
    end
    c = 2'b00;
    cv = 1'b0;
    case (kind)
      0: r = a + b;
      1: begin
        r = a - b;
        cv = 1'b1;
        c[0] = (a == b);
        c[1] = ($signed(a) > $signed(b));
      end
      2: r = a & b;
      3: r = a | b;
      default: r = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
    endcase
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      ev = 1'b0; er = '0; ec = '0; ecv = 1'b0; ereq = "R1";
    end else begin
      bit rdy;
      rdy = !ev || out_ready;
      if (in_valid && rdy) begin
        ref_calc(in_class, in_func, in_a, in_b, er, ec, ecv, ereq);
        ev = 1'b1;
      end else if (out_ready) begin
        ev = 1'b0;
      end
    end
  end

  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      chk(out_valid == ev, "R9", "out_valid", {31'b0, out_valid}, {31'b0, ev});
      chk(in_ready == (!ev || out_ready), "R9", "in_ready", {31'b0, in_ready},
          {31'b0, (!ev || out_ready)});
      if (ev) begin
        chk(out_result == er, ereq, "result", out_result, er);
        chk(out_cmp_valid == ecv, ecv ? "R7" : "R8", "cmp_valid",
            {31'b0, out_cmp_valid}, {31'b0, ecv});
        chk(out_cmp == ec, ecv ? "R7" : "R8", "cmp", {30'b0, out_cmp}, {30'b0, ec});
      end
    end
  end

  task automatic send(input logic [1:0] cls, input logic [5:0] fc,
                      input logic [31:0] a, input logic [31:0] b);
    bit acc;
    acc = 1'b0;
    while (!acc) begin
      @(negedge clk);
      in_valid  = 1'b1;
      in_class  = cls;
      in_func   = fc;
      in_a      = a;
      in_b      = b;
      out_ready = stall_mode ? (($urandom % 3) != 0) : 1'b1;
      #1;
      acc = in_ready;
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_func  = 6'($urandom);
    out_ready = stall_mode ? (($urandom % 3) != 0) : 1'b1;
  endtask

  function automatic logic [31:0] pick();
    case ($urandom % 8)
      0: return 32'h0000_0000;
      1: return 32'h7FFF_FFFF;
      2: return 32'h8000_0000;
      3: return 32'hFFFF_FFFF;
      4: return 32'h0000_0001;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    // R1: outputs during reset
    #1;
    chk(out_valid == 1'b0, "R1", "out_valid in reset", {31'b0, out_valid}, 32'd0);
    chk(out_result == 32'd0, "R1", "result in reset", out_result, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(in_ready == 1'b1, "R1", "in_ready after reset", {31'b0, in_ready}, 32'd1);
    chk({out_cmp, out_cmp_valid} == 3'b000, "R1", "cmp after reset",
        {29'b0, out_cmp, out_cmp_valid}, 32'd0);

    // directed: R2 R3 R4 R5 R6 R7 R8 R11
    send(2'b00, 6'h22, 32'hFFFF_FFFF, 32'h0000_0001);
    send(2'b01, 6'h20, 32'h0000_0005, 32'h0000_0005);
    send(2'b01, 6'h2A, 32'h7FFF_FFFF, 32'h8000_0000);
    send(2'b01, 6'h00, 32'h8000_0000, 32'h7FFF_FFFF);
    send(2'b01, 6'h25, 32'hFFFF_FFFF, 32'h0000_0001);
    send(2'b10, 6'h20, 32'h1234_5678, 32'h1111_1111);
    send(2'b10, 6'h22, 32'h0000_0003, 32'h0000_0007);
    send(2'b10, 6'h24, 32'hF0F0_F0F0, 32'h3C3C_3C3C);
    send(2'b10, 6'h25, 32'hF0F0_0000, 32'h0000_0F0F);
    send(2'b10, 6'h2A, 32'h8000_0000, 32'h7FFF_FFFF);
    send(2'b10, 6'h2A, 32'h7FFF_FFFF, 32'h8000_0000);
    send(2'b10, 6'h2A, 32'h0000_0004, 32'h0000_0004);
    send(2'b10, 6'h3F, 32'h0000_0010, 32'h0000_0020);
    send(2'b11, 6'h22, 32'h0000_0010, 32'h0000_0020);

    // R10: hold under back-pressure, random stream
    stall_mode = 1'b1;
    for (int i = 0; i < 3000; i++) begin
      logic [5:0] fc;
      case ($urandom % 7)
        0: fc = 6'h20;
        1: fc = 6'h22;
        2: fc = 6'h24;
        3: fc = 6'h25;
        4: fc = 6'h2A;
        default: fc = 6'($urandom);
      endcase
      send(2'($urandom), fc, pick(), pick());
      if (($urandom % 5) == 0) begin
        repeat ($urandom % 3) @(negedge clk);
      end
    end
    stall_mode = 1'b0;
    @(negedge clk);
    out_ready = 1'b1;
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule